// File: doc/BRIEF.md
# Thermal Throttle and Body-Bias Controller

This block watches a group of on-chip temperature sensors and turns their readings into operating-point targets for a processor cluster. A poll counter fires at a programmable period. Each poll samples one sensor in round-robin order. After every complete pass over the sensors, the hottest reading of that pass is latched.

The latched maximum drives three decisions:
- **Throttling.** Throttling starts when the maximum is above an upper limit and ends when it is below a lower limit. Between the two limits the current state holds, which gives hysteresis.
- **Interrupt.** The start and end of throttling each set a sticky status flag. Software clears each flag with a one-cycle clear pulse. A level interrupt stays high while either flag is set.
- **Body bias.** Reverse body bias is wanted when the maximum is above a breakeven temperature. That temperature is chosen by a process-bin select, so bins with similar silicon can share one entry.

Supply and frequency codes come from a normal or a throttled table entry. Reverse bias costs speed, so a voltage compensation offset is added to the supply code whenever the boost is active. The sequencer keeps the boost active during bias transitions. The supply is raised, then after a settle interval the bias is applied. On release, the bias is removed first, and the boost drops one settle interval later.

Top module: `thermal_guard`

## Requirements
- R1: One poll strobe (`sns_rd` high for one cycle) fires every `cfg_period` cycles. Each strobe samples `sns_data` for sensor `sns_sel`. `sns_sel` then advances by one, wrapping from NSENS-1 to 0.
- R2: On the strobe for sensor NSENS-1, `max_temp` takes the largest reading of the pass that started at sensor 0.
- R3: The cycle after a new `max_temp` is latched, `throttle` is updated:
  - It sets if it was clear and `max_temp` > `cfg_hi`.
  - It clears if it was set and `max_temp` < `cfg_lo`.
  - Otherwise it holds.
- R4: `frq_code` equals `cfg_frq_thr` while `throttle` is high and `cfg_frq_norm` otherwise. The base supply code is chosen between `cfg_vdd_thr` and `cfg_vdd_norm` in the same way.
- R5: The flag `stat_start` sets on the edge where `throttle` rises, and `stat_end` sets on the edge where `throttle` falls. Each flag stays set until its clear input is high at a clock edge; a set on the same edge takes priority over the clear. `irq` is high while either flag is high.
- R6: The bias request is updated on the same edge as `throttle`. It is true when `max_temp` is strictly greater than the breakeven byte for bin `cfg_bin`, which is taken from `cfg_brk[8*cfg_bin+7 : 8*cfg_bin]`.
- R7: Bias sequencing follows the request:
  - When the request is seen, `vdd_boost` rises one cycle later, and `bias_on` follows `cfg_settle`+1 cycles after that.
  - When the request goes away, `bias_on` falls one cycle later, and `vdd_boost` falls `cfg_settle`+1 cycles after that.
  - A wait that has begun always runs to its end.
- R8: `vdd_code` is the base supply code, plus `cfg_vcomp` while `vdd_boost` is high, saturating at 255. `bias_code` equals `cfg_bias` while `bias_on` is high and 0 otherwise.
- R9: In reset and on the first cycle after it, the outputs are:
  - `throttle`, `irq`, both status flags, `bias_on`, `vdd_boost` and `max_temp` are 0.
  - `sns_sel` is 0.
  - `vdd_code` and `frq_code` carry the normal entries.
- R10: A `cfg_period` of 0 or 1 gives a poll strobe on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | 16 | Poll period in cycles |
| cfg_hi | input | 8 | Upper thermal limit, °C |
| cfg_lo | input | 8 | Lower thermal limit, °C |
| cfg_bin | input | 2 | Process-bin select |
| cfg_brk | input | 32 | Breakeven temperature per bin, one byte each |
| cfg_settle | input | 8 | Settle wait count |
| cfg_vdd_norm | input | 8 | Supply code, normal |
| cfg_frq_norm | input | 8 | Frequency code, normal |
| cfg_vdd_thr | input | 8 | Supply code, throttled |
| cfg_frq_thr | input | 8 | Frequency code, throttled |
| cfg_vcomp | input | 8 | Supply offset while boosted |
| cfg_bias | input | 8 | Body-bias code when applied |
| clr_start | input | 1 | Clear pulse for `stat_start` |
| clr_end | input | 1 | Clear pulse for `stat_end` |
| sns_data | input | 8 | Reading of the selected sensor |
| sns_rd | output | 1 | Poll strobe |
| sns_sel | output | 2 | Selected sensor index |
| max_temp | output | 8 | Hottest reading of the last pass |
| throttle | output | 1 | Throttling active |
| irq | output | 1 | Level interrupt |
| stat_start | output | 1 | Sticky throttle-entry flag |
| stat_end | output | 1 | Sticky throttle-exit flag |
| vdd_code | output | 8 | Supply target |
| frq_code | output | 8 | Frequency target |
| bias_code | output | 8 | Body-bias target |
| bias_on | output | 1 | Body bias applied |
| vdd_boost | output | 1 | Compensation offset active |

## Verification
The assertions assume that the thresholds, breakeven bytes and table entries do not change between a scan result and the throttle update that follows it. They also assume that every clear input is a pulse written by software. The stimulus changes configuration only in long quiet stretches, well clear of the edges the checked relations depend on, and it drives each clear input high for exactly one cycle. Sensor readings are held constant for several whole scan passes, so that every pass sees one consistent set of temperatures.

// File: rtl/tg_pkg.sv
package tg_pkg;
    typedef enum logic [1:0] {
        BS_IDLE  = 2'd0,
        BS_BOOST = 2'd1,
        BS_LIVE  = 2'd2,
        BS_DRAIN = 2'd3
    } bias_state_e;
endpackage

// File: rtl/tg_scan.sv
module tg_scan #(
    parameter int NSENS = 4,
    parameter int TW    = 8,
    parameter int PW    = 16,
    localparam int IW   = $clog2(NSENS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] cfg_period,
    input  logic [TW-1:0] sns_data,
    output logic          sns_rd,
    output logic [IW-1:0] sns_sel,
    output logic [TW-1:0] max_temp,
    output logic          scan_done
);
    typedef struct packed {
        logic [PW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [TW-1:0] run;
        logic [TW-1:0] mx;
        logic          done;
    } scan_t;

    scan_t s_d, s_q;
    logic [PW:0]   cnt_nx;
    logic          poll;
    logic [TW-1:0] hot;

    always_comb begin
        s_d    = s_q;
        s_d.done = 1'b0;
        cnt_nx = {1'b0, s_q.cnt} + {{PW{1'b0}}, 1'b1};
        poll   = cnt_nx >= {1'b0, cfg_period};
        hot    = (s_q.idx == '0 || sns_data > s_q.run) ? sns_data : s_q.run;
        if (poll) begin
            s_d.cnt = '0;
            s_d.run = hot;
            if (s_q.idx == IW'(NSENS - 1)) begin
                s_d.idx  = '0;
                s_d.mx   = hot;
                s_d.done = 1'b1;
            end else begin
                s_d.idx = s_q.idx + IW'(1);
            end
        end else begin
            s_d.cnt = cnt_nx[PW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sns_rd    = poll;
    assign sns_sel   = s_q.idx;
    assign max_temp  = s_q.mx;
    assign scan_done = s_q.done;
endmodule

// File: rtl/tg_policy.sv
module tg_policy #(
    parameter int TW   = 8,
    parameter int NBIN = 4,
    localparam int BW  = $clog2(NBIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_done,
    input  logic [TW-1:0]      max_temp,
    input  logic [TW-1:0]      cfg_hi,
    input  logic [TW-1:0]      cfg_lo,
    input  logic [BW-1:0]      cfg_bin,
    input  logic [NBIN*TW-1:0] cfg_brk,
    input  logic               clr_start,
    input  logic               clr_end,
    output logic               throttle,
    output logic               stat_start,
    output logic               stat_end,
    output logic               bias_want
);
    typedef struct packed {
        logic thr;
        logic ss;
        logic se;
        logic want;
    } pol_t;

    pol_t p_d, p_q;
    logic [TW-1:0] brk_a [NBIN];
    logic set_s, set_e;

    for (genvar g = 0; g < NBIN; g++) begin : g_brk
        assign brk_a[g] = cfg_brk[g*TW +: TW];
    end

    always_comb begin
        p_d   = p_q;
        set_s = 1'b0;
        set_e = 1'b0;
        if (scan_done) begin
            if (!p_q.thr && max_temp > cfg_hi) begin
                p_d.thr = 1'b1;
                set_s   = 1'b1;
            end else if (p_q.thr && max_temp < cfg_lo) begin
                p_d.thr = 1'b0;
                set_e   = 1'b1;
            end
            p_d.want = max_temp > brk_a[cfg_bin];
        end
        p_d.ss = set_s | (p_q.ss & ~clr_start);
        p_d.se = set_e | (p_q.se & ~clr_end);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign throttle   = p_q.thr;
    assign stat_start = p_q.ss;
    assign stat_end   = p_q.se;
    assign bias_want  = p_q.want;
endmodule

// File: rtl/tg_opseq.sv
module tg_opseq
    import tg_pkg::*;
#(
    parameter int CW = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          throttle,
    input  logic          bias_want,
    input  logic [SW-1:0] cfg_settle,
    input  logic [CW-1:0] cfg_vdd_norm,
    input  logic [CW-1:0] cfg_frq_norm,
    input  logic [CW-1:0] cfg_vdd_thr,
    input  logic [CW-1:0] cfg_frq_thr,
    input  logic [CW-1:0] cfg_vcomp,
    input  logic [CW-1:0] cfg_bias,
    output logic [CW-1:0] vdd_code,
    output logic [CW-1:0] frq_code,
    output logic [CW-1:0] bias_code,
    output logic          bias_on,
    output logic          vdd_boost
);
    typedef struct packed {
        bias_state_e   st;
        logic [SW-1:0] cnt;
    } seq_t;

    seq_t q_d, q_q;
    logic [CW-1:0] base;
    logic [CW:0]   sum;

    always_comb begin
        q_d = q_q;
        unique case (q_q.st)
            BS_IDLE: if (bias_want) begin
                q_d.st  = BS_BOOST;
                q_d.cnt = '0;
            end
            BS_BOOST: if (q_q.cnt == cfg_settle) q_d.st = BS_LIVE;
                      else q_d.cnt = q_q.cnt + SW'(1);
            BS_LIVE: if (!bias_want) begin
                q_d.st  = BS_DRAIN;
                q_d.cnt = '0;
            end
            BS_DRAIN: if (q_q.cnt == cfg_settle) q_d.st = BS_IDLE;
                      else q_d.cnt = q_q.cnt + SW'(1);
            default: q_d.st = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '{st: BS_IDLE, cnt: '0};
        else        q_q <= q_d;
    end

    assign vdd_boost = q_q.st != BS_IDLE;
    assign bias_on   = q_q.st == BS_LIVE;
    assign base      = throttle ? cfg_vdd_thr : cfg_vdd_norm;
    assign sum       = {1'b0, base} + (vdd_boost ? {1'b0, cfg_vcomp} : '0);
    assign vdd_code  = sum[CW] ? '1 : sum[CW-1:0];
    assign frq_code  = throttle ? cfg_frq_thr : cfg_frq_norm;
    assign bias_code = bias_on ? cfg_bias : '0;
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard #(
    parameter int NSENS = 4,
    parameter int TW    = 8,
    parameter int PW    = 16,
    parameter int NBIN  = 4,
    parameter int CW    = 8,
    parameter int SW    = 8,
    localparam int IW   = $clog2(NSENS),
    localparam int BW   = $clog2(NBIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PW-1:0]      cfg_period,
    input  logic [TW-1:0]      cfg_hi,
    input  logic [TW-1:0]      cfg_lo,
    input  logic [BW-1:0]      cfg_bin,
    input  logic [NBIN*TW-1:0] cfg_brk,
    input  logic [SW-1:0]      cfg_settle,
    input  logic [CW-1:0]      cfg_vdd_norm,
    input  logic [CW-1:0]      cfg_frq_norm,
    input  logic [CW-1:0]      cfg_vdd_thr,
    input  logic [CW-1:0]      cfg_frq_thr,
    input  logic [CW-1:0]      cfg_vcomp,
    input  logic [CW-1:0]      cfg_bias,
    input  logic               clr_start,
    input  logic               clr_end,
    input  logic [TW-1:0]      sns_data,
    output logic               sns_rd,
    output logic [IW-1:0]      sns_sel,
    output logic [TW-1:0]      max_temp,
    output logic               throttle,
    output logic               irq,
    output logic               stat_start,
    output logic               stat_end,
    output logic [CW-1:0]      vdd_code,
    output logic [CW-1:0]      frq_code,
    output logic [CW-1:0]      bias_code,
    output logic               bias_on,
    output logic               vdd_boost
);
    logic scan_done;
    logic bias_want;

    tg_scan #(.NSENS(NSENS), .TW(TW), .PW(PW)) u_scan (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .sns_data(sns_data),
        .sns_rd(sns_rd), .sns_sel(sns_sel), .max_temp(max_temp), .scan_done(scan_done)
    );

    tg_policy #(.TW(TW), .NBIN(NBIN)) u_policy (
        .clk(clk), .rst_n(rst_n), .scan_done(scan_done), .max_temp(max_temp),
        .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .cfg_bin(cfg_bin), .cfg_brk(cfg_brk),
        .clr_start(clr_start), .clr_end(clr_end), .throttle(throttle),
        .stat_start(stat_start), .stat_end(stat_end), .bias_want(bias_want)
    );

    tg_opseq #(.CW(CW), .SW(SW)) u_opseq (
        .clk(clk), .rst_n(rst_n), .throttle(throttle), .bias_want(bias_want),
        .cfg_settle(cfg_settle), .cfg_vdd_norm(cfg_vdd_norm), .cfg_frq_norm(cfg_frq_norm),
        .cfg_vdd_thr(cfg_vdd_thr), .cfg_frq_thr(cfg_frq_thr), .cfg_vcomp(cfg_vcomp),
        .cfg_bias(cfg_bias), .vdd_code(vdd_code), .frq_code(frq_code),
        .bias_code(bias_code), .bias_on(bias_on), .vdd_boost(vdd_boost)
    );

    assign irq = stat_start | stat_end;
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
    parameter int NSENS = 4,
    parameter int TW    = 8,
    localparam int IW   = $clog2(NSENS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] cfg_hi,
    input logic [TW-1:0] cfg_lo,
    input logic          clr_start,
    input logic          sns_rd,
    input logic [IW-1:0] sns_sel,
    input logic [TW-1:0] max_temp,
    input logic          throttle,
    input logic          stat_start,
    input logic          bias_on,
    input logic          vdd_boost
);
    // R1: selection advances by one (with wrap) after every poll strobe
    assert_sel_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sns_rd |=> sns_sel == (($past(sns_sel) == IW'(NSENS - 1)) ? '0 : $past(sns_sel) + IW'(1)));

    // R3: entry only above the upper limit, exit only below the lower limit
    assert_enter_above_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(throttle) |-> max_temp > cfg_hi);
    assert_exit_below_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(throttle) |-> max_temp < cfg_lo);

    // R5: the entry flag sets with throttle entry and holds until cleared
    assert_start_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(throttle) |-> stat_start);
    assert_start_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_start && !clr_start) |=> stat_start);

    // R7: supply boost is in place before bias appears and stays until bias is gone
    assert_boost_before_bias_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bias_on) |-> $past(vdd_boost));
    assert_bias_gone_before_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vdd_boost) |-> !$past(bias_on));
    assert_bias_needs_boost_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bias_on |-> vdd_boost);
endmodule

bind thermal_guard tg_checker #(.NSENS(NSENS), .TW(TW)) i_tg_checker (
    .clk(clk), .rst_n(rst_n), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
    .clr_start(clr_start), .sns_rd(sns_rd), .sns_sel(sns_sel),
    .max_temp(max_temp), .throttle(throttle), .stat_start(stat_start),
    .bias_on(bias_on), .vdd_boost(vdd_boost)
);

// File: tb/test_thermal_guard.sv
module test_thermal_guard;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_period = 16'd3;
    logic [7:0]  cfg_hi = 8'd90, cfg_lo = 8'd70;
    logic [1:0]  cfg_bin = 2'd0;
    logic [31:0] cfg_brk = {8'd100, 8'd80, 8'd75, 8'd65};
    logic [7:0]  cfg_settle = 8'd2;
    logic [7:0]  cfg_vdd_norm = 8'd100, cfg_frq_norm = 8'd200;
    logic [7:0]  cfg_vdd_thr = 8'd80, cfg_frq_thr = 8'd120;
    logic [7:0]  cfg_vcomp = 8'd5, cfg_bias = 8'd40;
    logic        clr_start = 1'b0, clr_end = 1'b0;
    logic [7:0]  sns_data;
    logic        sns_rd, throttle, irq, stat_start, stat_end, bias_on, vdd_boost;
    logic [1:0]  sns_sel;
    logic [7:0]  max_temp, vdd_code, frq_code, bias_code;

    int temps [NS];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign sns_data = 8'(temps[sns_sel]);

    thermal_guard i_thermal_guard (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_hi(cfg_hi),
        .cfg_lo(cfg_lo), .cfg_bin(cfg_bin), .cfg_brk(cfg_brk), .cfg_settle(cfg_settle),
        .cfg_vdd_norm(cfg_vdd_norm), .cfg_frq_norm(cfg_frq_norm),
        .cfg_vdd_thr(cfg_vdd_thr), .cfg_frq_thr(cfg_frq_thr), .cfg_vcomp(cfg_vcomp),
        .cfg_bias(cfg_bias), .clr_start(clr_start), .clr_end(clr_end),
        .sns_data(sns_data), .sns_rd(sns_rd), .sns_sel(sns_sel), .max_temp(max_temp),
        .throttle(throttle), .irq(irq), .stat_start(stat_start), .stat_end(stat_end),
        .vdd_code(vdd_code), .frq_code(frq_code), .bias_code(bias_code),
        .bias_on(bias_on), .vdd_boost(vdd_boost)
    );

    // Behavioural reference
    int m_cnt, m_idx, m_run, m_max, m_thr, m_ss, m_se, m_want, m_phase, m_wait;
    bit m_done;

    function automatic bit ref_poll();
        return (m_cnt + 1) >= int'(cfg_period);
    endfunction

    always @(posedge clk) begin
        int hot, n_thr, n_ss, n_se, n_want, n_phase, n_wait, n_idx, n_run, n_max, n_cnt;
        bit n_done;
        if (!rst_n) begin
            m_cnt = 0; m_idx = 0; m_run = 0; m_max = 0; m_done = 0;
            m_thr = 0; m_ss = 0; m_se = 0; m_want = 0; m_phase = 0; m_wait = 0;
        end else begin
            n_cnt = m_cnt + 1; n_idx = m_idx; n_run = m_run; n_max = m_max; n_done = 0;
            if (ref_poll()) begin
                n_cnt = 0;
                hot = (m_idx == 0) ? temps[m_idx] : ((temps[m_idx] > m_run) ? temps[m_idx] : m_run);
                n_run = hot;
                if (m_idx == NS - 1) begin
                    n_idx = 0; n_max = hot; n_done = 1;
                end else n_idx = m_idx + 1;
            end
            n_thr = m_thr; n_want = m_want;
            n_ss = clr_start ? 0 : m_ss;
            n_se = clr_end ? 0 : m_se;
            if (m_done) begin
                if (m_thr == 0 && m_max > int'(cfg_hi)) begin n_thr = 1; n_ss = 1; end
                else if (m_thr == 1 && m_max < int'(cfg_lo)) begin n_thr = 0; n_se = 1; end
                n_want = (m_max > int'(cfg_brk[cfg_bin*8 +: 8])) ? 1 : 0;
            end
            n_phase = m_phase; n_wait = m_wait;
            case (m_phase)
                0: if (m_want == 1) begin n_phase = 1; n_wait = 0; end
                1: if (m_wait == int'(cfg_settle)) n_phase = 2; else n_wait = m_wait + 1;
                2: if (m_want == 0) begin n_phase = 3; n_wait = 0; end
                default: if (m_wait == int'(cfg_settle)) n_phase = 0; else n_wait = m_wait + 1;
            endcase
            m_cnt = n_cnt; m_idx = n_idx; m_run = n_run; m_max = n_max; m_done = n_done;
            m_thr = n_thr; m_ss = n_ss; m_se = n_se; m_want = n_want;
            m_phase = n_phase; m_wait = n_wait;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, sampled away from the active edge
    always @(negedge clk) begin
        int base, vdd;
        if (rst_n && !done) begin
            base = m_thr ? int'(cfg_vdd_thr) : int'(cfg_vdd_norm);
            vdd  = base + ((m_phase != 0) ? int'(cfg_vcomp) : 0);
            if (vdd > 255) vdd = 255;
            check("R1", "sns_rd", int'(sns_rd), int'(ref_poll()));
            check("R1", "sns_sel", int'(sns_sel), m_idx);
            check("R2", "max_temp", int'(max_temp), m_max);
            check("R3", "throttle", int'(throttle), m_thr);
            check("R4", "frq_code", int'(frq_code), m_thr ? int'(cfg_frq_thr) : int'(cfg_frq_norm));
            check("R5", "stat_start", int'(stat_start), m_ss);
            check("R5", "stat_end", int'(stat_end), m_se);
            check("R5", "irq", int'(irq), (m_ss | m_se));
            check("R7", "vdd_boost", int'(vdd_boost), int'(m_phase != 0));
            check("R7", "bias_on", int'(bias_on), int'(m_phase == 2));
            check("R8", "vdd_code", int'(vdd_code), vdd);
            check("R8", "bias_code", int'(bias_code), (m_phase == 2) ? int'(cfg_bias) : 0);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_all(int t);
        for (int i = 0; i < NS; i++) temps[i] = t;
    endtask

    task automatic pulse_clr(bit s, bit e);
        clr_start = s; clr_end = e;
        step(1);
        clr_start = 0; clr_end = 0;
    endtask

    initial begin
        set_all(50);
        step(3);
        // R9: reset values, sampled while reset is held
        #1;
        check("R9", "throttle in reset", int'(throttle), 0);
        check("R9", "irq in reset", int'(irq), 0);
        check("R9", "bias_on in reset", int'(bias_on), 0);
        check("R9", "vdd_boost in reset", int'(vdd_boost), 0);
        check("R9", "sns_sel in reset", int'(sns_sel), 0);
        check("R9", "vdd_code in reset", int'(vdd_code), 100);
        check("R9", "frq_code in reset", int'(frq_code), 200);
        rst_n = 1'b1;
        step(40);
        // R3/R6/R7: one hot sensor starts throttling and bias
        temps[2] = 95;
        step(40);
        check("R3", "throttle after hot pass", int'(throttle), 1);
        check("R6", "bias_on above bin0 breakeven", int'(bias_on), 1);
        check("R8", "vdd boosted throttled", int'(vdd_code), 85);
        pulse_clr(1, 0);
        // R3: between the limits the state holds
        set_all(80);
        step(40);
        check("R3", "throttle held between limits", int'(throttle), 1);
        check("R5", "start flag cleared", int'(stat_start), 0);
        // R3/R7: cool down, exit throttling and release bias
        set_all(60);
        step(40);
        check("R3", "throttle exited", int'(throttle), 0);
        check("R5", "end flag set", int'(stat_end), 1);
        check("R7", "boost released", int'(vdd_boost), 0);
        pulse_clr(0, 1);
        // R6: bin 1 breakeven 75 -> 70 gives no bias, 76 does
        cfg_bin = 2'd1;
        set_all(70);
        step(40);
        check("R6", "no bias at 70 in bin1", int'(bias_on), 0);
        temps[0] = 76;
        step(40);
        check("R6", "bias at 76 in bin1", int'(bias_on), 1);
        // R8: saturation of the compensated supply code
        cfg_vdd_norm = 8'd250; cfg_vcomp = 8'd10;
        step(2);
        check("R8", "vdd saturated", int'(vdd_code), 255);
        // R10: period 0 and 1 poll every cycle
        cfg_period = 16'd0;
        step(6);
        check("R10", "strobe each cycle period0", int'(sns_rd), 1);
        cfg_period = 16'd1;
        set_all(92);
        step(30);
        check("R10", "strobe each cycle period1", int'(sns_rd), 1);
        check("R3", "throttle at fast polling", int'(throttle), 1);
        // R7: longer settle on release
        cfg_settle = 8'd7;
        set_all(40);
        step(40);
        check("R7", "bias off after long settle", int'(bias_on), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule